// File: doc/BRIEF.md
# Satellite Ranging Code Generator with Phase Offset

This block produces the 1023-chip coarse ranging code of one navigation satellite, chosen through a 5-bit identifier. Two 10-bit linear feedback shift registers are combined, and the second register is read through a pair of taps that depends on the satellite. Each code chip lasts one slot between chip-rate ticks, and the chip is XORed with a 1-bit message input on its way to the carrier mixer.

When the block is enabled, a slot counter starts at zero and advances once per tick. The code is held back until the slot counter first equals the configured phase, taken modulo 1023. From that slot on, the generated sequence runs continuously. Its chip 0 lands on every slot whose position equals the phase, so the output is the code delayed by the phase in chips. A single-clock start strobe marks each of those slots. An acquisition engine under test can use it as a timing reference.

Top module: `ca_code_gen`

## Requirements
- R1: While `en_i` is low, `chip_o` and `start_o` are 0 and the slot position, alignment and both registers return to their initial state; raising `en_i` starts at slot 0.
- R2: Register A is 10 stages with feedback stage3 XOR stage10. Register B is 10 stages with feedback from stages 2, 3, 6, 8, 9 and 10. Both start at all ones and shift the feedback into stage 1. Code chip = A.stage10 XOR B.stageX XOR B.stageY. Identifier 0 yields the first ten chips 1,1,0,0,1,0,0,0,0,0.
- R3: Identifier n selects the tap pair of code number n+1 in the public table. Examples: 0 → (2,6), 9 → (2,3), 22 → (1,3), 31 → (4,9).
- R4: The slot position advances by one on a clock with `tick_i` and `en_i` high, and wraps from 1022 to 0. Without a tick it holds.
- R5: The effective phase is `phase_i` modulo 1023, so 1023 acts as 0 and 65535 acts as 63.
- R6: For slot index k counted from enable, and effective phase p, `chip_o` is 0 for k < p. For k ≥ p it is code chip (k−p) mod 1023 XOR `msg_i`.
- R7: `start_o` is high for exactly the first clock of every slot whose position equals the effective phase, and low otherwise.
- R8: `msg_i` inverts `chip_o` combinationally, within the same cycle, once the code is running. It has no effect before alignment.
- R9: The code repeats every 1023 slots: both registers reload to all ones at the end of code chip 1022.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low clears the generator |
| tick_i | input | 1 | Chip-rate strobe, one clock per slot |
| sat_id_i | input | 5 | Satellite identifier (code number minus one) |
| phase_i | input | 16 | Code phase in chips, reduced modulo 1023 |
| msg_i | input | 1 | Navigation message bit |
| chip_o | output | 1 | Modulated code chip |
| start_o | output | 1 | One-clock strobe at the phase slot |

## Verification
A single wrong stage in either register corrupts `chip_o` within a few slots. It stays wrong from then on, because the code no longer matches the expected sequence. A fault in the slot counter or in the phase reduction first shows as `start_o` and the start of the code landing on the wrong slot. That error is visible at the first alignment, at most 1023 slots after enable. A bad reload persists until code chip 1022 is reached, then shows as a broken second period. Two consecutive periods are therefore compared for each case.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int unsigned CODE_LEN = 1023;
  localparam int unsigned LFSR_W   = 10;
  localparam int unsigned ID_W     = 5;
  localparam int unsigned PHASE_W  = 16;

  // tap pair for register B, stage numbers 1..10, packed {x,y}
  function automatic logic [7:0] b_taps(input logic [ID_W-1:0] id);
    case (id)
      5'd0:  return {4'd2, 4'd6};
      5'd1:  return {4'd3, 4'd7};
      5'd2:  return {4'd4, 4'd8};
      5'd3:  return {4'd5, 4'd9};
      5'd4:  return {4'd1, 4'd9};
      5'd5:  return {4'd2, 4'd10};
      5'd6:  return {4'd1, 4'd8};
      5'd7:  return {4'd2, 4'd9};
      5'd8:  return {4'd3, 4'd10};
      5'd9:  return {4'd2, 4'd3};
      5'd10: return {4'd3, 4'd4};
      5'd11: return {4'd5, 4'd6};
      5'd12: return {4'd6, 4'd7};
      5'd13: return {4'd7, 4'd8};
      5'd14: return {4'd8, 4'd9};
      5'd15: return {4'd9, 4'd10};
      5'd16: return {4'd1, 4'd4};
      5'd17: return {4'd2, 4'd5};
      5'd18: return {4'd3, 4'd6};
      5'd19: return {4'd4, 4'd7};
      5'd20: return {4'd5, 4'd8};
      5'd21: return {4'd6, 4'd9};
      5'd22: return {4'd1, 4'd3};
      5'd23: return {4'd4, 4'd6};
      5'd24: return {4'd5, 4'd7};
      5'd25: return {4'd6, 4'd8};
      5'd26: return {4'd7, 4'd9};
      5'd27: return {4'd8, 4'd10};
      5'd28: return {4'd1, 4'd6};
      5'd29: return {4'd2, 4'd7};
      5'd30: return {4'd3, 4'd8};
      default: return {4'd4, 4'd9};
    endcase
  endfunction
endpackage

// File: rtl/ca_slot_tracker.sv
module ca_slot_tracker #(
  parameter int unsigned LEN     = 1023,
  parameter int unsigned PHASE_W = 16,
  localparam int unsigned CW     = $clog2(LEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               match_o,
  output logic               running_o,
  output logic               reload_o
);
  logic [CW-1:0] pos_q, pos_nxt, eff_ph;
  logic          aligned_q;

  assign eff_ph    = CW'(phase_i % PHASE_W'(LEN));
  assign pos_nxt   = (pos_q == CW'(LEN - 1)) ? '0 : pos_q + 1'b1;
  assign match_o   = en_i && (pos_q == eff_ph);
  assign running_o = en_i && (aligned_q || match_o);
  assign reload_o  = (pos_nxt == eff_ph);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      aligned_q <= 1'b0;
    end else if (!en_i) begin
      pos_q     <= '0;
      aligned_q <= 1'b0;
    end else if (tick_i) begin
      pos_q <= pos_nxt;
      if (match_o) aligned_q <= 1'b1;
    end
  end

  // R4
  pos_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < CW'(LEN));
  // R4
  pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(pos_q));
  // R1
  pos_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pos_q == '0 && !aligned_q));
endmodule

// File: rtl/ca_lfsr_pair.sv
module ca_lfsr_pair
  import ca_pkg::*;
#(
  parameter int unsigned W = LFSR_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            step_i,
  input  logic            reload_i,
  input  logic [ID_W-1:0] sat_id_i,
  output logic            code_o,
  output logic            at_init_o
);
  logic [W-1:0] a_q, b_q;
  logic         a_fb, b_fb;
  logic [7:0]   taps;
  logic [3:0]   tx, ty;

  // bit i holds stage i+1
  assign a_fb = a_q[2] ^ a_q[9];
  assign b_fb = b_q[1] ^ b_q[2] ^ b_q[5] ^ b_q[7] ^ b_q[8] ^ b_q[9];
  assign taps = b_taps(sat_id_i);
  assign tx   = taps[7:4] - 4'd1;
  assign ty   = taps[3:0] - 4'd1;

  assign code_o    = a_q[W-1] ^ b_q[tx] ^ b_q[ty];
  assign at_init_o = (&a_q) && (&b_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '1;
      b_q <= '1;
    end else if (!en_i || (step_i && reload_i)) begin
      a_q <= '1;
      b_q <= '1;
    end else if (step_i) begin
      a_q <= {a_q[W-2:0], a_fb};
      b_q <= {b_q[W-2:0], b_fb};
    end
  end

  // R2
  a_never_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_q != '0);
  // R2
  b_never_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_q != '0);
  // R1
  idle_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> at_init_o);
endmodule

// File: rtl/ca_code_gen.sv
module ca_code_gen
  import ca_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic [ID_W-1:0]    sat_id_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               msg_i,
  output logic               chip_o,
  output logic               start_o
);
  logic match, running, reload, code, at_init, match_q;

  ca_slot_tracker #(.LEN(CODE_LEN), .PHASE_W(PHASE_W)) u_track (
    .clk_i, .rst_ni, .en_i, .tick_i, .phase_i,
    .match_o(match), .running_o(running), .reload_o(reload)
  );

  ca_lfsr_pair #(.W(LFSR_W)) u_lfsr (
    .clk_i, .rst_ni, .en_i,
    .step_i(tick_i && running), .reload_i(reload), .sat_id_i,
    .code_o(code), .at_init_o(at_init)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= match;
  end

  assign start_o = match && !match_q;
  assign chip_o  = running && (code ^ msg_i);

  // R9
  start_at_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> at_init);
  // R7
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!chip_o && !start_o));
endmodule

// File: tb/ca_code_gen_bench.sv
`timescale 1ns/1ps
module ca_code_gen_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0, tick_i = 1'b0, msg_i = 1'b0;
  logic [4:0]  sat_id_i = '0;
  logic [15:0] phase_i = '0;
  logic        chip_o, start_o;

  int n_cmp = 0, n_bad = 0;
  bit code_tab [1023];
  int ta [32] = '{2,3,4,5,1,2,1,2,3,2,3,5,6,7,8,9,1,2,3,4,5,6,1,4,5,6,7,8,1,2,3,4};
  int tb [32] = '{6,7,8,9,9,10,8,9,10,3,4,6,7,8,9,10,4,5,6,7,8,9,3,6,7,8,9,10,6,7,8,9};

  ca_code_gen u_ca_code_gen (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void build(input int id);
    bit [1:10] a = '1, b = '1;
    bit fa, fb;
    for (int k = 0; k < 1023; k++) begin
      code_tab[k] = a[10] ^ b[ta[id]] ^ b[tb[id]];
      fa = a[3] ^ a[10];
      fb = b[2] ^ b[3] ^ b[6] ^ b[8] ^ b[9] ^ b[10];
      a = {fa, a[1:9]};
      b = {fb, b[1:9]};
    end
  endfunction

  function automatic bit exp_chip(input int s, input int p, input bit m);
    if (s < p) return 1'b0;
    return code_tab[(s - p) % 1023] ^ m;
  endfunction

  task automatic run_case(input int id, input int ph, input int nslots, input bit first10);
    int p = ph % 1023;
    bit [9:0] ref10 = 10'b1100100000;
    bit m;
    build(id);
    @(negedge clk_i);
    en_i = 1'b0; tick_i = 1'b0; sat_id_i = 5'(id); phase_i = 16'(ph);
    repeat (3) @(negedge clk_i);
    #1 chk("R1 idle chip", chip_o, 0);
    chk("R1 idle start", start_o, 0);
    @(negedge clk_i);
    en_i = 1'b1;
    for (int s = 0; s < nslots; s++) begin
      // cycle 1 of slot
      tick_i = 1'b0;
      m = first10 ? 1'b0 : 1'($urandom);
      msg_i = m;
      #1;
      chk("R6 chip", chip_o, exp_chip(s, p, m));
      chk("R7 start", start_o, (s % 1023) == p);
      if (first10 && s < 10) chk("R2 first chips", chip_o, ref10[9 - s]);
      @(negedge clk_i);
      // cycle 2: message flip inside slot
      m = ~m; msg_i = m;
      #1;
      chk("R8 msg", chip_o, exp_chip(s, p, m));
      chk("R7 single", start_o, 0);
      @(negedge clk_i);
      #1 chk("R4 hold", chip_o, exp_chip(s, p, m));
      @(negedge clk_i);
      tick_i = 1'b1;
      @(negedge clk_i);
    end
    tick_i = 1'b0;
    en_i = 1'b0;
    #1 chk("R1 drop chip", chip_o, 0);
    chk("R1 drop start", start_o, 0);
  endtask

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1 chk("R1 reset chip", chip_o, 0);
    chk("R1 reset start", start_o, 0);
    run_case(0, 0, 1030, 1'b1);        // R2 R9 two periods
    run_case(9, 1023, 1030, 1'b0);     // R3 R5 1023 acts as 0
    run_case(31, 65535, 1100, 1'b0);   // R3 R5 -> 63
    run_case(22, 1022, 1030, 1'b0);    // R6 last-slot phase
    run_case(5, 1, 1030, 1'b0);
    for (int r = 0; r < 4; r++)
      run_case(int'($urandom % 32), int'($urandom % 65536), 1100, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule